// File: doc/BRIEF.md
# UART Receive Idle Timeout Counter

This block watches the receive side of a UART for silence. While the receiver is enabled, it counts bit-time ticks that come from the baud divider's clock domain. When the count runs out a software-programmed preset, it raises a sticky timeout status bit. Activity that shows data is moving restarts the count. Those restart events are: reaching a programmed number of received frames, data becoming ready while a data-transfer mode is selected, and any new write of the preset.

The bit-rate tick arrives as a level that toggles once per bit time. It is carried into the system clock domain by a synchronizer and an edge detector. The count that software reads is a registered copy of the internal counter, so reads see the counter as it stood a few system clocks earlier. The preset sits in the top twelve bits of a 32-bit register word, and the rest of that word reads as zero. A preset of 0, 1 or 2 is refused as a timeout setting: writing one flags the status bit at once.

Top module: `uart_rx_idle_timeout`

## Requirements
- R1: After reset, cur_cnt is 0, to_flag is 0 and pto_rdata is the reset preset 0xFFF placed in bits 31:20, with bits 19:0 zero.
- R2: A write puts pto_wdata[31:20] into the preset. pto_rdata returns it in bits 31:20, and bits 19:0 always read 0 whatever was written there.
- R3: While rx_en is 1 and the preset is legal, each change of level on tick_tgl raises the count by exactly one.
- R4: A tick_tgl change made before rising edge 1 is seen on cur_cnt after rising edge 4, and not after edge 3.
- R5: While rx_en is 0, the count is held at 0 and tick_tgl changes do not advance it.
- R6: With preset P (P of 3 or more), a tick that would take the count to P-1 instead returns it to 0 and sets to_flag. cur_cnt never shows P-1.
- R7: Any preset write clears the count. If a tick lands on the same edge as the write, the write wins and the count is 0.
- R8: Writing a preset of 0, 1 or 2 sets to_flag on the next edge. While such a preset is stored, the count stays 0 under ticks.
- R9: When exp_frames is not 0, the frame_done pulse that brings the number of received frames to exp_frames clears the count. When exp_frames is 0, frame_done has no effect on the count.
- R10: A data_ready pulse clears the count when xfer_mode is 1 and has no effect when xfer_mode is 0.
- R11: to_flag stays set until a to_clr pulse clears it. If a timeout or an illegal write falls on the same edge as to_clr, to_flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receiver enable; counting runs only while 1 |
| tick_tgl | input | 1 | Bit-time tick from the baud domain, one level change per bit |
| pto_wr | input | 1 | Write strobe for the preset register |
| pto_wdata | input | 32 | Write word; preset field in bits 31:20 |
| frame_done | input | 1 | One-cycle pulse per received frame |
| exp_frames | input | 4 | Expected frame count; 0 disables the frame clear |
| data_ready | input | 1 | One-cycle pulse when received data becomes ready |
| xfer_mode | input | 1 | Data-transfer mode select enabling the data-ready clear |
| to_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| cur_cnt | output | 12 | Software-visible current count |
| to_flag | output | 1 | Sticky timeout status |
| pto_rdata | output | 32 | Preset register read word |

## Verification
Two pairs of functions can act on the same edge, and the bench makes each pair collide on purpose. The first pair is a tick and a preset write. The bench changes tick_tgl, waits two edges so that the synchronized tick is live, and then raises pto_wr for the third edge. The count must read 0 afterwards and then restart from 1. The second pair is the final tick of a timeout and a to_clr strobe. The bench raises to_clr for the edge on which the wrap happens, and to_flag must still be set after that edge. A later lone to_clr must clear it.

// File: rtl/uart_to_pkg.sv
package uart_to_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned MIN_LEGAL = 3;

  typedef enum logic [1:0] {
    CAUSE_HOLD,
    CAUSE_OFF,
    CAUSE_RESTART,
    CAUSE_STEP
  } cnt_cause_e;
endpackage

// File: rtl/to_tick_sync.sv
module to_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], tgl_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/to_frame_tracker.sv
module to_frame_tracker #(
  parameter int unsigned FRM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             frame_done,
  input  logic [FRM_W-1:0] exp_frames,
  output logic             hit_o
);
  logic [FRM_W-1:0] fcnt_q;
  logic [FRM_W-1:0] fcnt_d;
  logic             fcnt_en;

  assign hit_o = rx_en && frame_done && (exp_frames != '0) &&
                 (fcnt_q == exp_frames - FRM_W'(1));

  always_comb begin
    fcnt_d  = fcnt_q;
    fcnt_en = 1'b0;
    if (!rx_en) begin
      fcnt_d  = '0;
      fcnt_en = 1'b1;
    end else if (frame_done) begin
      fcnt_d  = hit_o ? '0 : fcnt_q + FRM_W'(1);
      fcnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
    end else if (fcnt_en) begin
      fcnt_q <= fcnt_d;
    end
  end
endmodule

// File: rtl/to_preset_reg.sv
module to_preset_reg
  import uart_to_pkg::*;
#(
  parameter int unsigned      CNT_W   = 12,
  parameter logic [CNT_W-1:0] PTO_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wfield,
  output logic [CNT_W-1:0] preset_q,
  output logic             legal_o,
  output logic             ill_wr_o,
  output logic [REG_W-1:0] rdata
);
  localparam int unsigned LOW_W = REG_W - CNT_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= PTO_RST;
    end else if (wr) begin
      preset_q <= wfield;
    end
  end

  assign legal_o  = preset_q >= CNT_W'(MIN_LEGAL);
  assign ill_wr_o = wr && (wfield < CNT_W'(MIN_LEGAL));
  assign rdata    = {preset_q, {LOW_W{1'b0}}};
endmodule

// File: rtl/to_core.sv
module to_core
  import uart_to_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tick,
  input  logic             restart,
  input  logic             legal,
  input  logic [CNT_W-1:0] preset,
  input  logic             ill_wr,
  input  logic             to_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  cnt_cause_e       cause;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             flag_d;
  logic             wrap;

  assign wrap = tick && legal && (cnt_q == preset - CNT_W'(2));

  always_comb begin
    if (!rx_en)        cause = CAUSE_OFF;
    else if (restart)  cause = CAUSE_RESTART;
    else if (!legal)   cause = CAUSE_OFF;
    else if (tick)     cause = CAUSE_STEP;
    else               cause = CAUSE_HOLD;
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    case (cause)
      CAUSE_OFF, CAUSE_RESTART: cnt_d = '0;
      CAUSE_STEP:               cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
      default:                  cnt_en = 1'b0;
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (to_clr) flag_d = 1'b0;
    if ((cause == CAUSE_STEP && wrap) || ill_wr) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/uart_rx_idle_timeout.sv
module uart_rx_idle_timeout
  import uart_to_pkg::*;
#(
  parameter int unsigned      CNT_W       = 12,
  parameter int unsigned      FRM_W       = 4,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] PTO_RST     = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tick_tgl,
  input  logic             pto_wr,
  input  logic [31:0]      pto_wdata,
  input  logic             frame_done,
  input  logic [FRM_W-1:0] exp_frames,
  input  logic             data_ready,
  input  logic             xfer_mode,
  input  logic             to_clr,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             to_flag,
  output logic [31:0]      pto_rdata
);
  localparam int unsigned FIELD_LSB = REG_W - CNT_W;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             tick;
  logic             frame_hit;
  logic             restart;
  logic [CNT_W-1:0] preset_q;
  logic             legal;
  logic             ill_wr;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  to_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tgl_in (tick_tgl),
    .tick_o (tick)
  );

  to_frame_tracker #(.FRM_W(FRM_W)) u_frm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_en      (rx_en),
    .frame_done (frame_done),
    .exp_frames (exp_frames),
    .hit_o      (frame_hit)
  );

  to_preset_reg #(.CNT_W(CNT_W), .PTO_RST(PTO_RST)) u_pto (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (pto_wr),
    .wfield   (pto_wdata[REG_W-1:FIELD_LSB]),
    .preset_q (preset_q),
    .legal_o  (legal),
    .ill_wr_o (ill_wr),
    .rdata    (pto_rdata)
  );

  assign restart = pto_wr || frame_hit || (data_ready && xfer_mode);

  to_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_en   (rx_en),
    .tick    (tick),
    .restart (restart),
    .legal   (legal),
    .preset  (preset_q),
    .ill_wr  (ill_wr),
    .to_clr  (to_clr),
    .cnt_q   (cnt_q),
    .flag_q  (to_flag)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cur_cnt <= '0;
    end else begin
      cur_cnt <= cnt_q;
    end
  end
endmodule

// File: rtl/uart_rx_idle_timeout_chk.sv
module uart_rx_idle_timeout_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             pto_wr,
  input logic [31:0]      pto_wdata,
  input logic             to_clr,
  input logic             to_flag,
  input logic [CNT_W-1:0] cur_cnt,
  input logic [31:0]      pto_rdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] preset_q
);
  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pto_rdata[31-CNT_W:0] == '0);

  // R4
  visible_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cur_cnt == $past(cnt_q));

  // R5
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> cnt_q == '0);

  // R6
  never_preset_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_q >= CNT_W'(3)) |-> cnt_q != preset_q - CNT_W'(1));

  // R7
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pto_wr |=> cnt_q == '0);

  // R8
  illegal_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pto_wr && pto_wdata[31:32-CNT_W] < CNT_W'(3)) |=> to_flag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !to_clr) |=> to_flag);
endmodule

bind uart_rx_idle_timeout uart_rx_idle_timeout_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rx_en     (rx_en),
  .pto_wr    (pto_wr),
  .pto_wdata (pto_wdata),
  .to_clr    (to_clr),
  .to_flag   (to_flag),
  .cur_cnt   (cur_cnt),
  .pto_rdata (pto_rdata),
  .cnt_q     (cnt_q),
  .preset_q  (preset_q)
);

// File: tb/sim_uart_rx_idle_timeout.sv
`timescale 1ns/1ps
module sim_uart_rx_idle_timeout;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_en, tick_tgl, pto_wr, frame_done, data_ready, xfer_mode, to_clr;
  logic [31:0] pto_wdata;
  logic [3:0]  exp_frames;
  logic [11:0] cur_cnt;
  logic        to_flag;
  logic [31:0] pto_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  uart_rx_idle_timeout u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick_tgl(tick_tgl),
    .pto_wr(pto_wr), .pto_wdata(pto_wdata), .frame_done(frame_done),
    .exp_frames(exp_frames), .data_ready(data_ready), .xfer_mode(xfer_mode),
    .to_clr(to_clr), .cur_cnt(cur_cnt), .to_flag(to_flag), .pto_rdata(pto_rdata)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nx(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    tick_tgl = ~tick_tgl;
    nx(4);
  endtask

  task automatic write_pto(int v, logic [19:0] junk);
    pto_wr = 1'b1;
    pto_wdata = {v[11:0], junk};
    nx(1);
    pto_wr = 1'b0;
    nx(1);
  endtask

  task automatic clear_flag();
    to_clr = 1'b1;
    nx(1);
    to_clr = 1'b0;
    nx(1);
  endtask

  task automatic pulse_frame();
    frame_done = 1'b1;
    nx(1);
    frame_done = 1'b0;
    nx(1);
  endtask

  task automatic pulse_ready();
    data_ready = 1'b1;
    nx(1);
    data_ready = 1'b0;
    nx(1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; tick_tgl = 1'b0; pto_wr = 1'b0; pto_wdata = '0;
    frame_done = 1'b0; exp_frames = '0; data_ready = 1'b0; xfer_mode = 1'b0; to_clr = 1'b0;
    nx(3);
    rst_n = 1'b1;
    nx(3);

    // R1 reset state
    check("R1 cnt", int'(cur_cnt), 0);
    check("R1 flag", int'(to_flag), 0);
    check("R1 rdata", int'(pto_rdata == 32'hFFF0_0000), 1);

    // R5 ticks ignored while disabled
    for (int i = 0; i < 3; i++) tick();
    check("R5 disabled", int'(cur_cnt), 0);

    rx_en = 1'b1;
    nx(2);
    // R2 readback with junk in the low bits
    write_pto(5, 20'hABCDE);
    check("R2 rdata", int'(pto_rdata == 32'h0050_0000), 1);
    write_pto(12'h9A3, 20'hFFFFF);
    check("R2 rdata2", int'(pto_rdata == 32'h9A30_0000), 1);

    // R3 / R6 sweep over presets
    for (int p = 3; p <= 9; p++) begin
      write_pto(p, 20'h0);
      clear_flag();
      for (int k = 1; k <= p; k++) begin
        tick();
        check("R3 count", int'(cur_cnt), k % (p - 1));
        check("R6 flag", int'(to_flag), (k >= p - 1) ? 1 : 0);
      end
    end

    // R4 visible lag
    write_pto(20, 20'h0);
    clear_flag();
    tick_tgl = ~tick_tgl;
    nx(3);
    check("R4 before edge4", int'(cur_cnt), 0);
    nx(1);
    check("R4 after edge4", int'(cur_cnt), 1);

    // R7 write clears, and wins over a same-edge tick
    tick(); tick();
    check("R7 pre", int'(cur_cnt), 3);
    write_pto(20, 20'h0);
    check("R7 write clears", int'(cur_cnt), 0);
    tick();
    tick_tgl = ~tick_tgl;
    nx(2);
    pto_wr = 1'b1; pto_wdata = {12'd20, 20'h0};
    nx(1);
    pto_wr = 1'b0;
    nx(2);
    check("R7 write beats tick", int'(cur_cnt), 0);
    tick();
    check("R7 restart", int'(cur_cnt), 1);

    // R8 illegal presets
    for (int v = 0; v < 3; v++) begin
      clear_flag();
      check("R8 flag cleared", int'(to_flag), 0);
      pto_wr = 1'b1; pto_wdata = {v[11:0], 20'h0};
      nx(1);
      pto_wr = 1'b0;
      check("R8 flag at once", int'(to_flag), 1);
      tick(); tick();
      check("R8 held", int'(cur_cnt), 0);
    end
    write_pto(20, 20'h0);
    check("R11 sticky after legal write", int'(to_flag), 1);
    clear_flag();
    check("R11 cleared", int'(to_flag), 0);

    // R10 data-ready clear
    tick(); tick(); tick();
    xfer_mode = 1'b0;
    pulse_ready();
    check("R10 mode0 no effect", int'(cur_cnt), 3);
    xfer_mode = 1'b1;
    pulse_ready();
    check("R10 mode1 clears", int'(cur_cnt), 0);
    xfer_mode = 1'b0;

    // R9 frame count
    exp_frames = 4'd3;
    tick(); tick();
    pulse_frame(); pulse_frame();
    check("R9 before count", int'(cur_cnt), 2);
    pulse_frame();
    check("R9 count reached", int'(cur_cnt), 0);
    exp_frames = 4'd0;
    tick();
    for (int i = 0; i < 5; i++) pulse_frame();
    check("R9 disabled", int'(cur_cnt), 1);

    // R11 timeout and clear on the same edge
    write_pto(4, 20'h0);
    clear_flag();
    tick(); tick();
    tick_tgl = ~tick_tgl;
    nx(2);
    to_clr = 1'b1;
    nx(1);
    to_clr = 1'b0;
    check("R11 set beats clear", int'(to_flag), 1);
    nx(1);
    check("R6 wrapped", int'(cur_cnt), 0);
    clear_flag();
    nx(3);
    check("R11 clear holds", int'(to_flag), 0);

    // R5 disabling clears the count
    tick();
    check("R5 pre", int'(cur_cnt), 1);
    rx_en = 1'b0;
    nx(2);
    check("R5 cleared", int'(cur_cnt), 0);
    tick();
    check("R5 held", int'(cur_cnt), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule